// File: doc/BRIEF.md
# Transmit Data-Link Bit Inserter with Zero Stuffing

This block feeds a low-rate data-link channel carried inside a framed serial line. A host hands it one byte at a time. The framer pulses `tx_req` each time it reaches a data-link bit position in the outgoing frame. On each pulse the block supplies one bit on `tx_bit`, least significant bit first. Framing positions, flags and CRC generation belong to other logic.

The host side is a valid/ready byte port backed by a one-byte holding slot. `wr_ready` is high exactly when the slot is empty. A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. A byte written while another is going out waits in the slot. It replaces the current byte when the first data bit of the next byte is requested. While the slot is full the host is held off; this is the only back-pressure. If the slot is still empty when the next byte starts, the previous byte is sent again. The framer side has no back-pressure: every `tx_req` consumes a bit.

With `stuff_en` high, a zero stuffer follows HDLC-style transparency. After five consecutive 1 data bits, the next request returns an inserted 0 instead of a data bit. A sticky `tx_empty` flag marks each completed byte. When `irq_en` is high, the flag drives the active-low `irq_n`.

Top module: `tdl_tx_inserter`

## Requirements
- R1: While `tx_req` is high at a clock edge, the bit on `tx_bit` in that cycle is consumed. `tx_bit` is the next data bit of the current byte, bit 0 first and bit 7 last, except when R7 applies.
- R2: After the eighth data bit is consumed, the next data bit is bit 0 of the following byte.
- R3: `tx_empty` is 1 after reset. It goes to 1 in the cycle after the request that consumes bit 7 of a byte. It goes to 0 in the cycle after a host write is accepted. If both happen in the same cycle, the write wins.
- R4: `irq_n` is 0 exactly when `tx_empty` is 1 and `irq_en` is 1; otherwise it is 1.
- R5: If no byte is pending when bit 0 of the next byte is requested, the previous byte is transmitted again, unchanged.
- R6: `wr_ready` is 1 exactly when the holding slot is empty. An accepted byte does not disturb the byte in progress. It becomes the transmitted byte from the first data bit of the next byte, and the slot frees on that request.
- R7: With `stuff_en` = 1, the request following five consecutive transmitted 1 data bits returns 0. That request consumes no data bit and restarts the run count, so an 8-bit byte with one insertion spans 9 requests.
- R8: The run of 1s is counted across byte boundaries. A run that ends one byte and continues into the next is stuffed at the fifth 1.
- R9: With `stuff_en` = 0, no bit is inserted. A byte always spans exactly 8 requests, even one with seven consecutive 1s.
- R10: After reset the current byte is 0x00, the slot is empty, the run count is 0 and the bit position is bit 0. Requests before any write therefore return 0s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte valid |
| wr_data | input | 8 | Host byte to transmit |
| wr_ready | output | 1 | Holding slot empty, byte accepted when valid |
| stuff_en | input | 1 | Enable zero insertion after five 1s |
| irq_en | input | 1 | Allow `tx_empty` to drive the interrupt |
| tx_req | input | 1 | Framer strobe at a data-link bit position |
| tx_bit | output | 1 | Bit for the current request |
| tx_empty | output | 1 | Sticky byte-completed flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Several checks hold on every cycle:
- the bit index steps by one and wraps after the last bit;
- an inserted zero leaves the bit index untouched and clears the run count;
- the run count climbs on each 1;
- a pending byte stays intact until it is taken;
- the empty flag sets and clears on the right edges.

Other behaviours need whole sequences and only the bench scenarios can show them:
- the full LSB-first bit order;
- retransmission of a stale byte;
- stuffing of a run split across two bytes;
- a mid-byte write that leaves the byte in flight intact.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  parameter int TDL_BYTE_W  = 8;
  parameter int TDL_RUN_LEN = 5;
endpackage

// File: rtl/tdl_hold_slot.sv
module tdl_hold_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         take,
  output logic         pend_valid,
  output logic [W-1:0] pend_data
);
  assign wr_ready = !pend_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_data  <= '0;
    end else if (wr_valid && wr_ready) begin
      pend_valid <= 1'b1;
      pend_data  <= wr_data;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // R6: a held byte stays intact until the shifter takes it
  assert_hold_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !take) |=> (pend_valid && $stable(pend_data)));
endmodule

// File: rtl/tdl_byte_shifter.sv
module tdl_byte_shifter #(
  parameter int W = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_fire,
  input  logic             pend_valid,
  input  logic [W-1:0]     pend_data,
  output logic             data_bit,
  output logic             take,
  output logic             byte_done,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(W - 1);

  logic [W-1:0] cur_byte;
  logic         at_first;
  logic         at_last;

  assign at_first  = (bit_idx == '0);
  assign at_last   = (bit_idx == LAST_IDX);
  assign data_bit  = (at_first && pend_valid) ? pend_data[0] : cur_byte[bit_idx];
  assign take      = data_fire && at_first && pend_valid;
  assign byte_done = data_fire && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_byte <= '0;
      bit_idx  <= '0;
    end else begin
      if (take) cur_byte <= pend_data;
      if (data_fire) bit_idx <= at_last ? '0 : bit_idx + 1'b1;
    end
  end

  // R2: the index returns to bit 0 after the last data bit
  assert_idx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_idx == '0));
  // R1: each consumed data bit moves to the next position
  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && !at_last) |=> (bit_idx == $past(bit_idx) + 1'b1));
endmodule

// File: rtl/tdl_zero_stuffer.sv
module tdl_zero_stuffer #(
  parameter int RUN = 5,
  localparam int CNT_W = $clog2(RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic stuff_en,
  input  logic data_bit,
  output logic tx_bit,
  output logic data_fire
);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN);

  logic [CNT_W-1:0] ones_run;
  logic             stuff_now;

  assign stuff_now = stuff_en && (ones_run == RUN_MAX);
  assign tx_bit    = stuff_now ? 1'b0 : data_bit;
  assign data_fire = tx_req && !stuff_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_run <= '0;
    end else if (tx_req) begin
      if (stuff_now || !data_bit) ones_run <= '0;
      else if (ones_run != RUN_MAX) ones_run <= ones_run + 1'b1;
    end
  end

  // R7: an inserted zero restarts the run
  assert_stuff_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && stuff_now) |=> (ones_run == '0));
  // R8: a 1 data bit extends the run whatever byte it belongs to
  assert_run_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && data_bit && ones_run != RUN_MAX) |=> (ones_run == $past(ones_run) + 1'b1));
endmodule

// File: rtl/tdl_empty_flag.sv
module tdl_empty_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_done,
  input  logic wr_fire,
  input  logic irq_en,
  output logic tx_empty,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)         tx_empty <= 1'b1;
    else if (wr_fire)   tx_empty <= 1'b0;
    else if (byte_done) tx_empty <= 1'b1;
  end

  assign irq_n = !(tx_empty && irq_en);

  // R3: completion sets the flag unless a write lands in the same cycle
  assert_empty_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wr_fire) |=> tx_empty);
  // R3: an accepted write clears the flag
  assert_empty_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !tx_empty);
endmodule

// File: rtl/tdl_tx_inserter.sv
module tdl_tx_inserter #(
  parameter int BYTE_W  = tdl_pkg::TDL_BYTE_W,
  parameter int RUN_LEN = tdl_pkg::TDL_RUN_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              stuff_en,
  input  logic              irq_en,
  input  logic              tx_req,
  output logic              tx_bit,
  output logic              tx_empty,
  output logic              irq_n
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic              pend_valid;
  logic [BYTE_W-1:0] pend_data;
  logic              take;
  logic              data_bit;
  logic              data_fire;
  logic              byte_done;
  logic [IDX_W-1:0]  bit_idx;
  logic              wr_fire;

  assign wr_fire = wr_valid && wr_ready;

  tdl_hold_slot #(.W(BYTE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .take(take), .pend_valid(pend_valid), .pend_data(pend_data)
  );

  tdl_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .data_fire(data_fire), .pend_valid(pend_valid),
    .pend_data(pend_data), .data_bit(data_bit), .take(take),
    .byte_done(byte_done), .bit_idx(bit_idx)
  );

  tdl_zero_stuffer #(.RUN(RUN_LEN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .stuff_en(stuff_en),
    .data_bit(data_bit), .tx_bit(tx_bit), .data_fire(data_fire)
  );

  tdl_empty_flag u_flag (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .wr_fire(wr_fire),
    .irq_en(irq_en), .tx_empty(tx_empty), .irq_n(irq_n)
  );

  // R7: a request that carries an inserted zero leaves the bit position alone
  assert_stuff_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !data_fire) |=> (bit_idx == $past(bit_idx)));
endmodule

// File: tb/tb_tdl_tx_inserter.sv
module tb_tdl_tx_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       stuff_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       tx_req = 1'b0;
  logic       tx_bit;
  logic       tx_empty;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tdl_tx_inserter dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .stuff_en(stuff_en), .irq_en(irq_en),
    .tx_req(tx_req), .tx_bit(tx_bit), .tx_empty(tx_empty), .irq_n(irq_n)
  );

  // {stuff_en, byte, requests, expected stream with bit k = k-th bit sent}
  localparam logic [29:0] VEC [0:4] = '{
    {1'b0, 8'h35, 5'd8, 16'h0035},
    {1'b0, 8'h7F, 5'd8, 16'h007F},
    {1'b1, 8'h7F, 5'd9, 16'h00DF},
    {1'b1, 8'h3E, 5'd9, 16'h003E},
    {1'b1, 8'h55, 5'd8, 16'h0055}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic get_bits(input int n, output logic [15:0] v);
    v = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tx_req = 1'b1;
      #1 v[k] = tx_bit;
      @(posedge clk);
      #1 tx_req = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 tx_empty", 16'(tx_empty), 16'h1);
    chk("R10 wr_ready", 16'(wr_ready), 16'h1);
    chk("R10 tx_bit", 16'(tx_bit), 16'h0);
    chk("R4 irq_n masked", 16'(irq_n), 16'h1);
    irq_en = 1'b1;
    #1 chk("R4 irq_n enabled", 16'(irq_n), 16'h0);
    irq_en = 1'b0;
    get_bits(8, v);
    chk("R10 reset byte", v, 16'h0000);

    // table walk: R1 order, R7 stuffing, R9 no stuffing
    for (int i = 0; i < 5; i++) begin
      stuff_en = VEC[i][29];
      put_byte(VEC[i][28:21]);
      chk("R3 write clears empty", 16'(tx_empty), 16'h0);
      get_bits(int'(VEC[i][20:16]), v);
      chk("R1/R7/R9 stream", v, VEC[i][15:0]);
      chk("R3 empty after byte", 16'(tx_empty), 16'h1);
    end

    // R5: no new byte, previous byte repeats
    get_bits(8, v);
    chk("R5 repeat", v, 16'h0055);

    // R6: write during a byte is held; R2 boundary
    stuff_en = 1'b0;
    put_byte(8'h12);
    get_bits(3, v);
    put_byte(8'h34);
    chk("R6 slot full", 16'(wr_ready), 16'h0);
    chk("R3 cleared by write", 16'(tx_empty), 16'h0);
    get_bits(5, w);
    chk("R6 byte in flight intact", v | (w << 3), 16'h0012);
    chk("R3 set at completion", 16'(tx_empty), 16'h1);
    get_bits(8, v);
    chk("R2 R6 pending byte next", v, 16'h0034);
    chk("R6 slot freed", 16'(wr_ready), 16'h1);

    // R8: run of 1s spanning two bytes
    stuff_en = 1'b1;
    put_byte(8'hE0);
    get_bits(8, v);
    chk("R8 first byte", v, 16'h00E0);
    put_byte(8'h03);
    get_bits(9, v);
    chk("R8 stuffed across boundary", v, 16'h0003);

    // R4 with flag set
    @(negedge clk);
    irq_en = 1'b1;
    #1 chk("R4 irq asserted", 16'(irq_n), 16'h0);
    put_byte(8'h00);
    #1 chk("R4 irq released by write", 16'(irq_n), 16'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule